// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block maps a 16-bit virtual address onto a 15-bit physical address through a 16-slot page table kept in flip-flops. Each slot describes one 4 KB virtual page. It holds a 3-bit frame number, a present flag and four permission flags: user access allowed, read, write and execute. A requester presents an address, the kind of access (read, write or instruction fetch) and whether it runs privileged. One clock later the block returns either the physical address or one of two fault flags. The page-fault flag means the page has no mapping. The protection-fault flag means the mapping exists but the access is not permitted.

Software fills and edits the table through a one-slot-per-cycle configuration port. Typical uses are mapping a page that faulted before retrying the access, or unmapping a page whose frame is being reclaimed. Reset leaves every slot unmapped, so each access faults until the table is filled.

Top module: `addr_xlat`

## Requirements
- R1: For a permitted access, the physical address is the entry's frame number times 4096 plus the low 12 bits of the virtual address, where the page index is virtual address bits 15:12. For example, 8196 on page 2 mapped to frame 6 gives 24580.
- R2: `rsp_valid` rises exactly one cycle after a cycle with `req_valid` high and is low in every other cycle; back-to-back requests give back-to-back responses in order.
- R3: After reset every entry is unmapped, so any access reports a page fault.
- R4: An access to an unmapped page sets `rsp_page_fault` and returns physical address 0.
- R5: A configuration write (`cfg_we` high) replaces the entry of page `cfg_page` with `cfg_data`. The layout is bit 7 present, bit 6 user allowed, bit 5 read, bit 4 write, bit 3 execute, bits 2:0 frame. Requests presented in later cycles use the new entry.
- R6: Writing an entry with its present bit clear makes later accesses to that page page-fault.
- R7: A user-mode access (`req_priv` = 0) to a present page whose user bit is clear sets `rsp_prot_fault`, whatever its access kind.
- R8: Access kinds are encoded as 00 read, 01 write and 10 fetch; each needs its own right bit. Kind 11 is never permitted. A denied access sets `rsp_prot_fault` and returns address 0.
- R9: A page fault takes priority: both fault flags are never high together, and an unmapped page never reports a protection fault.
- R10: A permitted access reports both fault flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_page | input | 4 | Page whose entry is written |
| cfg_data | input | 8 | New entry {present, user, read, write, exec, frame[2:0]} |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 15 | Physical address (0 on any fault) |
| rsp_page_fault | output | 1 | Page not mapped |
| rsp_prot_fault | output | 1 | Mapped but access not permitted |

## Verification
Translation is tried on addresses that combine different pages, frames and offsets, including offset 0 and a non-zero offset in the same page. This exposes a swapped or truncated offset and a wrong frame lookup. Each access kind runs against entries that grant exactly one right and in both modes, so a swapped right bit or an ignored mode bit appears as a wrong fault. Entries that are unmapped and also deny everything separate page-fault priority from protection checking. A map, retry and unmap sequence shows that table edits take effect on the next request.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;

  localparam int PERM_W = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_NONE  = 2'b11
  } acc_e;

  typedef struct packed {
    logic present;
    logic user_ok;
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  // right bit that matches the access kind
  function automatic logic kind_right(perm_t p, logic [1:0] kind);
    case (kind)
      ACC_READ:  return p.rd;
      ACC_WRITE: return p.wr;
      ACC_FETCH: return p.ex;
      default:   return 1'b0;
    endcase
  endfunction

  // full permission decision for a present entry
  function automatic logic access_allowed(perm_t p, logic [1:0] kind, logic priv);
    return kind_right(p, kind) && (priv || p.user_ok);
  endfunction

endpackage

// File: rtl/pte_table.sv
module pte_table #(
  parameter int PAGE_W = 4,
  parameter int ENT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [ENT_W-1:0]  rd_data
);
  localparam int PAGES = 1 << PAGE_W;

  logic [ENT_W-1:0] ent_q [PAGES];

  for (genvar g = 0; g < PAGES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[g] <= '0;
      else if (wr_en && wr_page == PAGE_W'(g))
        ent_q[g] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_page];

  // R5
  table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_page)] == $past(wr_data));

endmodule

// File: rtl/perm_check.sv
module perm_check
  import addr_xlat_pkg::*;
(
  input  perm_t       perm,
  input  logic [1:0]  kind,
  input  logic        priv,
  output logic        page_miss,
  output logic        prot_viol
);
  always_comb begin
    page_miss = !perm.present;
    prot_viol = perm.present && !access_allowed(perm, kind, priv);
  end
endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
  import addr_xlat_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [VA_W-1:0]              req_vaddr,
  input  logic [1:0]                   req_kind,
  input  logic                         req_priv,
  input  logic                         cfg_we,
  input  logic [VA_W-OFS_W-1:0]        cfg_page,
  input  logic [PERM_W+FRAME_W-1:0]    cfg_data,
  output logic                         rsp_valid,
  output logic [FRAME_W+OFS_W-1:0]     rsp_paddr,
  output logic                         rsp_page_fault,
  output logic                         rsp_prot_fault
);
  localparam int PAGE_W = VA_W - OFS_W;
  localparam int PA_W   = FRAME_W + OFS_W;
  localparam int ENT_W  = PERM_W + FRAME_W;

  function automatic logic [PA_W-1:0] join_pa(logic [FRAME_W-1:0] frame,
                                               logic [OFS_W-1:0] ofs);
    return {frame, ofs};
  endfunction

  // named internal events
  logic [PAGE_W-1:0]  req_page;
  logic [OFS_W-1:0]   req_ofs;
  logic [ENT_W-1:0]   ent;
  perm_t              ent_perm;
  logic [FRAME_W-1:0] ent_frame;
  logic               page_miss;
  logic               prot_viol;

  assign req_page  = req_vaddr[VA_W-1:OFS_W];
  assign req_ofs   = req_vaddr[OFS_W-1:0];
  assign ent_perm  = perm_t'(ent[ENT_W-1:FRAME_W]);
  assign ent_frame = ent[FRAME_W-1:0];

  pte_table #(.PAGE_W(PAGE_W), .ENT_W(ENT_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_page (cfg_page),
    .wr_data (cfg_data),
    .rd_page (req_page),
    .rd_data (ent)
  );

  perm_check u_perm (
    .perm      (ent_perm),
    .kind      (req_kind),
    .priv      (req_priv),
    .page_miss (page_miss),
    .prot_viol (prot_viol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_page_fault <= 1'b0;
      rsp_prot_fault <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_page_fault <= req_valid && page_miss;
      rsp_prot_fault <= req_valid && prot_viol;
      if (req_valid && !page_miss && !prot_viol)
        rsp_paddr <= join_pa(ent_frame, req_ofs);
      else
        rsp_paddr <= '0;
    end
  end

  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R9
  fault_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_page_fault |-> !rsp_prot_fault);

  // R4
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_page_fault || rsp_prot_fault) |-> rsp_paddr == '0);

  // R1
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_page_fault && !rsp_prot_fault
      |-> rsp_paddr[OFS_W-1:0] == $past(req_ofs));

  // R7
  user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_priv && ent_perm.present && !ent_perm.user_ok |=> rsp_prot_fault);

  // R3
  flags_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_page_fault && !rsp_prot_fault);

endmodule

// File: tb/addr_xlat_test.sv
module addr_xlat_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_page = '0;
  logic [7:0]  cfg_data = '0;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic        rsp_page_fault;
  logic        rsp_prot_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  shadow [16];
  logic [16:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlat uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
    .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault)
  );

  // expected {page_fault, prot_fault, paddr} from the requirement text
  function automatic logic [16:0] model(logic [7:0] e, logic [15:0] va,
                                        logic [1:0] k, logic pv);
    bit ok;
    int pa;
    if (e[7] == 1'b0) return {1'b1, 1'b0, 15'd0};
    if (k == 2'd0) ok = e[5];
    else if (k == 2'd1) ok = e[4];
    else if (k == 2'd2) ok = e[3];
    else ok = 0;
    if (!pv && !e[6]) ok = 0;
    if (!ok) return {1'b0, 1'b1, 15'd0};
    pa = int'(e[2:0]) * 4096 + int'(va) % 4096;
    return {2'b00, 15'(pa)};
  endfunction

  function automatic logic [7:0] mk(bit p, bit u, bit r, bit w, bit x, int fr);
    return {p, u, r, w, x, 3'(fr)};
  endfunction

  task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cfg(int page, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_page = 4'(page); cfg_data = d;
    shadow[page] = d;
  endtask

  task automatic req(string tag, logic [15:0] va, logic [1:0] k, logic pv);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_priv = pv;
    exp_q.push_back(model(shadow[va[15:12]], va, k, pv));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", 1'b0, 1, 0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " paddr"}, rsp_paddr == e[14:0], rsp_paddr, e[14:0]);
        check({t, " page_fault"}, rsp_page_fault == e[16], rsp_page_fault, e[16]);
        check({t, " prot_fault"}, rsp_prot_fault == e[15], rsp_prot_fault, e[15]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check("R2 reset valid", rsp_valid == 1'b0, rsp_valid, 0);
    check("R3 reset flags", rsp_page_fault == 1'b0 && rsp_prot_fault == 1'b0,
          {rsp_page_fault, rsp_prot_fault}, 0);
    rst_n = 1'b1;

    // R3: empty table faults everywhere
    req("R3 empty page0", 16'd0, 2'd0, 1'b1);
    req("R3 empty page15", 16'hFFFF, 2'd2, 1'b0);
    idle();

    // R5 fill entries, all rights, user allowed
    cfg(0, mk(1,1,1,1,1,2));
    cfg(1, mk(1,1,1,1,1,4));
    cfg(2, mk(1,1,1,1,1,6));
    cfg(5, mk(1,1,1,1,1,3));
    // R1: back-to-back translations (R2 ordering)
    req("R1 va0", 16'd0, 2'd0, 1'b0);
    req("R1 va8196", 16'd8196, 2'd1, 1'b0);
    req("R1 va20500", 16'd20500, 2'd2, 1'b1);
    req("R1 va1026", 16'd1026, 2'd0, 1'b1);
    req("R1 va4095", 16'd4095, 2'd0, 1'b0);
    idle();
    idle();
    check("R2 idle after burst", rsp_valid == 1'b0, rsp_valid, 0);

    // R4 unmapped page 8, then map it and retry (R5)
    req("R4 va32780 unmapped", 16'd32780, 2'd0, 1'b0);
    cfg(8, mk(1,1,1,1,1,1));
    req("R5 va32780 retried", 16'd32780, 2'd0, 1'b0);
    // R6 unmap page 1
    req("R6 page1 before", 16'd4100, 2'd0, 1'b0);
    cfg(1, mk(0,1,1,1,1,4));
    req("R6 page1 after", 16'd4100, 2'd0, 1'b0);

    // R7 privileged-only page 3, all rights
    cfg(3, mk(1,0,1,1,1,5));
    req("R7 user read", 16'h3010, 2'd0, 1'b0);
    req("R7 user fetch", 16'h3010, 2'd2, 1'b0);
    req("R7 priv read", 16'h3010, 2'd0, 1'b1);

    // R8 one-right entries
    cfg(4, mk(1,1,1,0,0,7)); // read only
    cfg(6, mk(1,1,0,1,0,0)); // write only
    cfg(7, mk(1,1,0,0,1,1)); // exec only
    for (int pg = 4; pg <= 7; pg++) begin
      for (int k = 0; k < 4; k++) begin
        req("R8 right matrix", 16'(pg * 4096 + 16'h0ABC), 2'(k), 1'b1);
      end
    end
    req("R8 user write readonly", 16'h4001, 2'd1, 1'b0);

    // R9 unmapped with no rights: page fault only
    cfg(9, mk(0,0,0,0,0,3));
    req("R9 unmapped no rights user", 16'h9123, 2'd1, 1'b0);
    req("R9 unmapped kind11", 16'h9123, 2'd3, 1'b1);
    // R10 permitted, with gap then single
    idle();
    req("R10 clean", 16'h2FFF, 2'd1, 1'b1);
    repeat (3) idle();
    check("R2 queue drained", exp_q.size() == 0, exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule